// File: doc/BRIEF.md
# Prioritised Interrupt Request Encoder with Acknowledge Responder

This block sits between a set of interrupting peripherals and a processor that takes its interrupt priority as a three-bit active-low code. Seven active-high request lines come in, with line k-1 standing for priority level k. The block registers the highest pending level and drives it inverted onto the level pins. The pins read all ones when nothing is requested, and all zeros for level 7, which the processor cannot mask.

The block also watches the processor bus for interrupt-acknowledge cycles. Such a cycle has the address strobe low and all three function-code bits high, and it carries the level being acknowledged on address bits 1 to 3. If that level has a pending request, the block answers in one of two ways, chosen per level. In the vectoring answer, it drives that level's 8-bit vector on the low data byte and asserts the data acknowledge. In the autovector answer, it asserts the valid-peripheral signal so that the processor supplies its own vector. The answer is held until the strobe is seen high. While an acknowledge cycle is in progress, the level pins are frozen, so the code the processor is acting on cannot change under it.

Top module: `irq_responder`

## Requirements
- R1: One clock edge after a request pattern is sampled, outside an acknowledge cycle, `ipl_no` equals the bitwise inverse of the highest requested level. Request bit k-1 means level k, and `ipl_no` reads 3'b111 when no request bit is set.
- R2: When several request bits are set, the highest-numbered level is the one encoded.
- R3: A request on bit 6 (level 7) drives `ipl_no` to 3'b000 whatever the lower request bits are.
- R4: A bus cycle counts as an acknowledge cycle only when `as_ni` is 0 and `fc_i` is 3'b111. With any other function code, or with the strobe high, no response is given.
- R5: While an acknowledge cycle is being sampled, `ipl_no` keeps its value even if the request lines change.
- R6: Suppose an acknowledge cycle names level L (1 to 7) on `addr_i[3:1]`, request bit L-1 is set and `auto_sel_i[L-1]` is 0. Then at the next edge `data_o` equals `vec_tbl_i[8*(L-1) +: 8]`, `data_oe_o` is 1, `dtack_no` is 0 and `vpa_no` is 1.
- R7: In the same situation with `auto_sel_i[L-1]` set to 1, the next edge gives `vpa_no` 0, `dtack_no` 1, `data_oe_o` 0 and `data_o` 0.
- R8: An acknowledge cycle that names level 0, or a level whose request bit is clear, gives no response: `dtack_no` and `vpa_no` stay 1 and `data_oe_o` stays 0.
- R9: Once a response is given, it is held with unchanged `data_o` while `as_ni` stays 0, even if the vector inputs or the requests change. It is released at the first edge that samples `as_ni` at 1.
- R10: While `rst_ni` is 0, `ipl_no` is 3'b111, `dtack_no` and `vpa_no` are 1, `data_oe_o` is 0 and `data_o` is 0.
- R11: `dtack_no` and `vpa_no` are never both 0, and `data_o` is 0 whenever `data_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 7 | Interrupt requests; bit k-1 is level k |
| vec_tbl_i | input | 56 | Vector numbers, 8 bits per level, level 1 in the lowest byte |
| auto_sel_i | input | 7 | Per level: 1 selects the autovector answer |
| fc_i | input | 3 | Processor function code |
| addr_i | input | 3 | Address bits 3 to 1; the acknowledged level |
| as_ni | input | 1 | Address strobe, active low |
| ipl_no | output | 3 | Encoded priority level, active low |
| data_o | output | 8 | Vector number for the low data byte |
| data_oe_o | output | 1 | Drive enable for `data_o` |
| dtack_no | output | 1 | Data acknowledge, active low |
| vpa_no | output | 1 | Autovector request, active low |

## Verification
Two functions can fall in the same cycle. A request change, including a new top-priority request, can arrive in the very cycle an acknowledge is sampled, and it can keep arriving while the response is being held. The bench provokes this by driving a new request pattern together with the strobe and function code, and by rewriting the vector inputs during the hold. A cycle-level scoreboard model, built from the requirements, then judges each edge. It expects the level pins frozen, the vector or autovector chosen from the level on the address bits, and the encoder moving to the new pattern only at the first edge after the strobe rises.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LVL = 7;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL + 1);
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned FC_W    = 3;

  typedef enum logic [1:0] {
    RESP_IDLE = 2'd0,
    RESP_VEC  = 2'd1,
    RESP_AUTO = 2'd2
  } resp_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = irq_pkg::NUM_LVL,
  parameter int unsigned LW = irq_pkg::LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          hold_i,
  output logic [LW-1:0] lvl_o
);
  logic [LW-1:0] enc;
  logic [LW-1:0] lvl_q;

  // later index overrides: highest set bit wins
  always_comb begin
    enc = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i]) enc = LW'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lvl_q <= '0;
    else if (!hold_i) lvl_q <= enc;
  end

  assign lvl_o = lvl_q;

  p_hold_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i)) |-> $stable(lvl_q));

  p_top_wins_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!hold_i) && $past(req_i[N-1])) |-> (lvl_q == LW'(N)));
endmodule

// File: rtl/irq_ack_match.sv
module irq_ack_match #(
  parameter int unsigned N   = irq_pkg::NUM_LVL,
  parameter int unsigned LW  = irq_pkg::LVL_W,
  parameter int unsigned VW  = irq_pkg::VEC_W,
  parameter int unsigned FCW = irq_pkg::FC_W
) (
  input  logic [FCW-1:0]  fc_i,
  input  logic            as_ni,
  input  logic [LW-1:0]   lvl_i,
  input  logic [N-1:0]    req_i,
  input  logic [N-1:0]    auto_sel_i,
  input  logic [N*VW-1:0] vec_tbl_i,
  output logic            ack_o,
  output logic            hit_o,
  output logic            auto_o,
  output logic [VW-1:0]   vec_o
);
  logic [VW-1:0] vec_arr [N];

  for (genvar g = 0; g < int'(N); g++) begin : g_vec
    assign vec_arr[g] = vec_tbl_i[g*VW +: VW];
  end

  assign ack_o = !as_ni && (&fc_i);

  // level 0 matches no slot
  always_comb begin
    hit_o  = 1'b0;
    auto_o = 1'b0;
    vec_o  = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (lvl_i == LW'(i + 1)) begin
        hit_o  = ack_o && req_i[i];
        auto_o = auto_sel_i[i];
        vec_o  = vec_arr[i];
      end
    end
  end
endmodule

// File: rtl/irq_resp.sv
module irq_resp #(
  parameter int unsigned VW = irq_pkg::VEC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          as_ni,
  input  logic          ack_i,
  input  logic          hit_i,
  input  logic          auto_i,
  input  logic [VW-1:0] vec_i,
  output logic [VW-1:0] data_o,
  output logic          data_oe_o,
  output logic          dtack_no,
  output logic          vpa_no
);
  import irq_pkg::*;

  resp_e         st_q, st_d;
  logic [VW-1:0] data_q, data_d;

  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    unique case (st_q)
      RESP_IDLE: begin
        if (hit_i) begin
          st_d   = auto_i ? RESP_AUTO : RESP_VEC;
          data_d = auto_i ? '0 : vec_i;
        end
      end
      RESP_VEC, RESP_AUTO: begin
        if (as_ni) begin
          st_d   = RESP_IDLE;
          data_d = '0;
        end
      end
      default: begin
        st_d   = RESP_IDLE;
        data_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RESP_IDLE;
      data_q <= '0;
    end else begin
      st_q   <= st_d;
      data_q <= data_d;
    end
  end

  assign data_o    = data_q;
  assign data_oe_o = (st_q == RESP_VEC);
  assign dtack_no  = (st_q != RESP_VEC);
  assign vpa_no    = (st_q != RESP_AUTO);

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dtack_no && !vpa_no));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_ni |=> (dtack_no && vpa_no && !data_oe_o));

  p_data_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dtack_no && $past(!dtack_no)) |-> $stable(data_o));

  p_start_needs_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != RESP_IDLE && $past(st_q) == RESP_IDLE) |-> $past(ack_i && hit_i));
endmodule

// File: rtl/irq_responder.sv
module irq_responder #(
  parameter int unsigned N   = irq_pkg::NUM_LVL,
  parameter int unsigned VW  = irq_pkg::VEC_W,
  parameter int unsigned FCW = irq_pkg::FC_W,
  localparam int unsigned LW = $clog2(N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic [N*VW-1:0] vec_tbl_i,
  input  logic [N-1:0]    auto_sel_i,
  input  logic [FCW-1:0]  fc_i,
  input  logic [3:1]      addr_i,
  input  logic            as_ni,
  output logic [LW-1:0]   ipl_no,
  output logic [VW-1:0]   data_o,
  output logic            data_oe_o,
  output logic            dtack_no,
  output logic            vpa_no
);
  logic          ack;
  logic          hit;
  logic          auto_sel;
  logic [VW-1:0] vec;
  logic [LW-1:0] lvl;
  logic [LW-1:0] ack_lvl;

  assign ack_lvl = LW'(addr_i);

  irq_prio_enc #(.N(N), .LW(LW)) u_enc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .hold_i (ack),
    .lvl_o  (lvl)
  );

  irq_ack_match #(.N(N), .LW(LW), .VW(VW), .FCW(FCW)) u_match (
    .fc_i       (fc_i),
    .as_ni      (as_ni),
    .lvl_i      (ack_lvl),
    .req_i      (req_i),
    .auto_sel_i (auto_sel_i),
    .vec_tbl_i  (vec_tbl_i),
    .ack_o      (ack),
    .hit_o      (hit),
    .auto_o     (auto_sel),
    .vec_o      (vec)
  );

  irq_resp #(.VW(VW)) u_resp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .as_ni     (as_ni),
    .ack_i     (ack),
    .hit_i     (hit),
    .auto_i    (auto_sel),
    .vec_i     (vec),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .dtack_no  (dtack_no),
    .vpa_no    (vpa_no)
  );

  assign ipl_no = ~lvl;

  p_no_resp_without_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ack) && !$past(hit) && $past(dtack_no) && $past(vpa_no))
      |-> (dtack_no && vpa_no));

  p_oe_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));
endmodule

// File: tb/irq_responder_test.sv
module irq_responder_test;
  localparam int N  = 7;
  localparam int VW = 8;

  typedef struct {
    logic [2:0]    ipl;
    logic          dtack;
    logic          vpa;
    logic          oe;
    logic [VW-1:0] data;
    string         tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*VW-1:0] vtbl = '0;
  logic [N-1:0]    asel = '0;
  logic [2:0]      fc = 3'b001;
  logic [3:1]      addr = '0;
  logic            as_n = 1'b1;
  logic [2:0]      ipl_no;
  logic [VW-1:0]   data_o;
  logic            data_oe_o, dtack_no, vpa_no;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;
  exp_t sb_q[$];

  // model state
  int            m_lvl = 0;
  int            m_st  = 0; // 0 idle, 1 vector, 2 auto
  logic [VW-1:0] m_data = '0;

  irq_responder uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .vec_tbl_i(vtbl),
    .auto_sel_i(asel), .fc_i(fc), .addr_i(addr), .as_ni(as_n),
    .ipl_no(ipl_no), .data_o(data_o), .data_oe_o(data_oe_o),
    .dtack_no(dtack_no), .vpa_no(vpa_no)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input exp_t e);
    n_checks++;
    if (ipl_no !== e.ipl || dtack_no !== e.dtack || vpa_no !== e.vpa ||
        data_oe_o !== e.oe || data_o !== e.data) begin
      n_errors++;
      $display("FAIL %s: got ipl=%b dtack=%b vpa=%b oe=%b data=%h exp ipl=%b dtack=%b vpa=%b oe=%b data=%h",
               tag, ipl_no, dtack_no, vpa_no, data_oe_o, data_o,
               e.ipl, e.dtack, e.vpa, e.oe, e.data);
    end
  endtask

  // apply inputs at negedge, predict the next edge, push expectation
  task automatic step(input string tag, input logic [N-1:0] r, input logic [2:0] f,
                      input logic [3:1] a, input logic s);
    bit   ack, hit;
    int   al;
    exp_t e;
    req = r; fc = f; addr = a; as_n = s;
    ack = !s && (f == 3'b111);
    al  = int'(a);
    hit = ack && al != 0 && r[al-1];
    if (!ack) begin
      m_lvl = 0;
      for (int i = 0; i < N; i++) if (r[i]) m_lvl = i + 1;
    end
    if (m_st == 0) begin
      if (hit) begin
        m_st   = asel[al-1] ? 2 : 1;
        m_data = asel[al-1] ? '0 : vtbl[8*(al-1) +: 8];
      end
    end else if (s) begin
      m_st = 0; m_data = '0;
    end
    e.ipl = ~3'(m_lvl); e.dtack = (m_st != 1); e.vpa = (m_st != 2);
    e.oe = (m_st == 1); e.data = m_data; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: sample a quarter period after the rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    exp_t rst_e;
    for (int i = 0; i < N; i++) vtbl[8*i +: 8] = 8'(8'h40 + 8'h11 * i);
    asel = 7'b000_0010; // level 2 autovectored
    #35;
    rst_e.ipl = 3'b111; rst_e.dtack = 1; rst_e.vpa = 1; rst_e.oe = 0; rst_e.data = '0;
    req = 7'b111_1111;
    #10;
    check("R10 reset", rst_e);
    req = '0;
    @(negedge clk);
    rst_ni = 1'b1;

    step("R1 idle",            7'b000_0000, 3'b001, 3'd0, 1'b1);
    step("R1 level3",          7'b000_0100, 3'b001, 3'd0, 1'b1);
    step("R2 levels 1,4,5",    7'b001_1001, 3'b001, 3'd0, 1'b1);
    step("R3 level7",          7'b100_0011, 3'b001, 3'd0, 1'b1);
    step("R1 level1",          7'b000_0001, 3'b001, 3'd0, 1'b1);
    // R4: strobe low but data function code
    step("R4 fc not ack",      7'b001_0000, 3'b110, 3'd5, 1'b0);
    step("R4 fc not ack hold", 7'b001_0000, 3'b101, 3'd5, 1'b0);
    step("R4 strobe high",     7'b001_0000, 3'b111, 3'd5, 1'b1);
    // R6 + R5: ack level 5, level 7 request arrives in same cycle
    step("R6 vector lvl5 / R5", 7'b101_0000, 3'b111, 3'd5, 1'b0);
    vtbl[8*4 +: 8] = 8'hEE;
    step("R9 hold vec change",  7'b100_0000, 3'b111, 3'd5, 1'b0);
    step("R9 hold req drop",    7'b000_0000, 3'b111, 3'd5, 1'b0);
    step("R9 release",          7'b100_0000, 3'b111, 3'd5, 1'b1);
    step("R1 after release",    7'b100_0000, 3'b001, 3'd0, 1'b1);
    // R7 autovector on level 2
    step("R7 setup",           7'b000_0010, 3'b001, 3'd0, 1'b1);
    step("R7 autovector lvl2", 7'b000_0010, 3'b111, 3'd2, 1'b0);
    step("R7 autovector hold", 7'b000_0010, 3'b111, 3'd2, 1'b0);
    step("R9 auto release",    7'b000_0010, 3'b111, 3'd2, 1'b1);
    // R8: no pending request at acked level, and level 0
    step("R8 unrequested lvl", 7'b000_0010, 3'b111, 3'd6, 1'b0);
    step("R8 unrequested end", 7'b000_0010, 3'b111, 3'd6, 1'b1);
    step("R8 level zero",      7'b111_1111, 3'b111, 3'd0, 1'b0);
    step("R8 level zero end",  7'b000_0000, 3'b001, 3'd0, 1'b1);
    // R6/R7 sweep over every level
    for (int l = 1; l <= N; l++) begin
      logic [N-1:0] r;
      r = N'(1) << (l - 1);
      step("R1 sweep setup",   r, 3'b001, 3'd0, 1'b1);
      step("R6 R7 sweep ack",  r, 3'b111, 3'(l), 1'b0);
      step("R11 sweep hold",   r, 3'b111, 3'(l), 1'b0);
      step("R9 sweep release", '0, 3'b001, 3'd0, 1'b1);
    end
    step("R1 final", '0, 3'b001, 3'd0, 1'b1);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule